// File: doc/BRIEF.md
# Decimal Signed-Digit Partial Product Reducer

This block adds the N+1 signed-digit decimal partial products of an N-by-N-digit decimal multiplier into a single radix-10 signed-digit product. Each partial product is N+2 digits wide and arrives from an upstream generator as one 4-bit two's complement value per digit plus one increment bit that is shared by all of its digits. The effective digit value is therefore the 4-bit value plus the increment bit, which spans [-8,8]. The block is purely combinational. It places partial product k k decimal places to the left and reduces every column with a two-level tree that contains only 4-operand radix-10 signed-digit adders.

The N low partial products are split into four groups, with partial products 4g to 4g+3 in group g. Each group feeds a first-level adder in every column. The top partial product comes from a multiplier digit that is only 0 or 1, so it is handled differently. Its digit h in any column is cut into four slices in [-2,2], and each slice goes into a different first-level adder. No fifth operand level is needed. The first level turns every position sum into a transfer digit in [-3,3] and an interim digit in [-5,4]. Both are fed straight into the second-level adder without an intermediate addition. The second level yields final digits in [-8,7].

The output keeps only product positions 0 to 2N, which is 2N+1 digits. Any weight of 10^(2N+1) or above is discarded, because a valid decimal product of two N-digit operands never needs it. N must be a multiple of four between 4 and 16.

Top module: `dsd_pp_reducer`

## Requirements
- R1: Take the output value as the sum over i of out digit i times 10^i, and the input value as the sum over k and j of the digit of partial product k at index j times 10^(k+j). Each top digit counts with weight 10^(N+j). The output value is congruent to the input value modulo 10^(2N+1).
- R2: Every digit is a 4-bit two's complement field. Low partial product k, digit j sits at bits (k*(N+2)+j)*4 upward. Top digit j sits at bits j*4 upward. Output digit i sits at bits i*4 upward. A low digit's value is its field plus the increment bit of its partial product.
- R3: A single value 1 placed at digit 0 of low partial product k, with all else zero, yields output digit k equal to 1 and every other output digit 0.
- R4: An increment bit applies to every digit of its partial product. Increment 1 on partial product 0 with all fields zero yields output digits 0 to N+1 equal to 1 and the rest 0.
- R5: The top operand's digit values are its field plus its own increment bit. They lie in [-4,6] for indices below N and in [0,1] at index N, and they are 0 at index N+1.
- R6: Every first-level position sum, meaning four low digits plus one slice, stays within [-34,34] for any legal input.
- R7: A top digit h is split into four slices in [-2,2], one per first-level adder. A lone h of 6 at top index 0 gives output digit N = -4 and digit N+1 = 1. A lone h of -4 gives output digit N = -4 only.
- R8: Second-level position sums stay within [-32,28], and every output digit lies in [-8,7].
- R9: A transfer out of position 2N is dropped. A lone low digit value 8 at partial product N-1, index N+1, yields output digit 2N = -2 and all other digits 0.
- R10: All-zero inputs yield an all-zero product, because unreached operand slots count as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pp_lo_dig | input | N*(N+2)*4 | Digit fields of the N low partial products |
| pp_lo_inc | input | N | Increment bit of each low partial product |
| pp_top_dig | input | (N+2)*4 | Digit fields of the top partial product |
| pp_top_inc | input | 1 | Increment bit of the top partial product |
| prod_dig | output | (2N+1)*4 | Signed-digit product, 4-bit two's complement per digit |

## Verification
The range assertions rely on the top operand having the shape that a 0-or-1 multiplier digit produces. This means digits in [-4,6], a top-but-one digit in [0,1] and a zero top digit. Low fields may take any 4-bit pattern. The stimulus therefore draws the intended top digit value first and derives the field by subtracting the increment bit, so every top vector stays legal. Low fields are drawn over all sixteen codes, which covers the extreme operand sums.

// File: rtl/dsd_pp_reducer.sv
module dsd_pp_reducer #(
  parameter int N = 16
) (
  input  logic [N*(N+2)*4-1:0] pp_lo_dig,
  input  logic [N-1:0]         pp_lo_inc,
  input  logic [(N+2)*4-1:0]   pp_top_dig,
  input  logic                 pp_top_inc,
  output logic [(2*N+1)*4-1:0] prod_dig
);
  localparam int W = N + 2;
  localparam int C = 2 * N + 1;
  localparam int G = 4;

  int ps1  [G][C];
  int sl   [G][C];
  int w1   [G][C];
  int tin1 [G][C];
  int ps2  [C];
  int w2   [C];
  int tin2 [C];
  int sd   [C];

  function automatic int xfer(input int ps);
    if (ps >= 25)       return 3;
    else if (ps >= 15)  return 2;
    else if (ps >= 5)   return 1;
    else if (ps >= -5)  return 0;
    else if (ps >= -15) return -1;
    else if (ps >= -25) return -2;
    else                return -3;
  endfunction

  function automatic int clamp2(input int v);
    if (v > 2)       return 2;
    else if (v < -2) return -2;
    else             return v;
  endfunction

  always_comb begin
    for (int g = 0; g < G; g++)
      for (int p = 0; p < C; p++) begin
        ps1[g][p]  = 0;
        sl[g][p]   = 0;
      end
    for (int k = 0; k < N; k++)
      for (int j = 0; j < W; j++)
        if (k + j < C)
          ps1[k / G][k + j] = ps1[k / G][k + j]
            + int'($signed(pp_lo_dig[(k*W+j)*4 +: 4])) + int'(pp_lo_inc[k]);
    for (int j = 0; j < W; j++)
      if (N + j < C) begin
        int rem;
        rem = int'($signed(pp_top_dig[j*4 +: 4])) + int'(pp_top_inc);
        for (int g = 0; g < G; g++) begin
          sl[g][N + j]  = clamp2(rem);
          rem           = rem - sl[g][N + j];
          ps1[g][N + j] = ps1[g][N + j] + sl[g][N + j];
        end
      end
    for (int g = 0; g < G; g++) begin
      tin1[g][0] = 0;
      for (int p = 0; p < C; p++) begin
        int t;
        t = xfer(ps1[g][p]);
        w1[g][p] = ps1[g][p] - 10 * t;
        if (p + 1 < C) tin1[g][p + 1] = t;
      end
    end
    tin2[0] = 0;
    for (int p = 0; p < C; p++) begin
      int t;
      ps2[p] = 0;
      for (int g = 0; g < G; g++) ps2[p] = ps2[p] + w1[g][p] + tin1[g][p];
      t = xfer(ps2[p]);
      w2[p] = ps2[p] - 10 * t;
      if (p + 1 < C) tin2[p + 1] = t;
    end
    for (int p = 0; p < C; p++) sd[p] = w2[p] + tin2[p];
  end

  for (genvar p = 0; p < C; p++) begin : g_out
    assign prod_dig[p*4 +: 4] = 4'(sd[p]);
  end

  always_comb begin
    for (int j = 0; j < W; j++) begin
      int h;
      h = int'($signed(pp_top_dig[j*4 +: 4])) + int'(pp_top_inc);
      if (j < N)       AST_TOP_BODY: assert (h >= -4 && h <= 6);  // R5
      else if (j == N) AST_TOP_NEXT: assert (h >= 0 && h <= 1);   // R5
      else             AST_TOP_ZERO: assert (h == 0);             // R5
    end
    for (int p = 0; p < C; p++) begin
      for (int g = 0; g < G; g++) begin
        AST_SLICE_RANGE: assert (sl[g][p] >= -2 && sl[g][p] <= 2);   // R7
        AST_L1_RANGE: assert (ps1[g][p] >= -34 && ps1[g][p] <= 34);  // R6
      end
      AST_L2_RANGE: assert (ps2[p] >= -32 && ps2[p] <= 28);          // R8
      AST_DIGIT_RANGE: assert (sd[p] >= -8 && sd[p] <= 7);           // R8
    end
  end
endmodule

// File: tb/dsd_pp_reducer_tb.sv
module dsd_pp_reducer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int W = N + 2;
  localparam int C = 2 * N + 1;

  typedef logic signed [191:0] big_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*W*4-1:0] lo_dig;
  logic [N-1:0]     lo_inc;
  logic [W*4-1:0]   top_dig;
  logic             top_inc;
  logic [C*4-1:0]   prod;

  int   n_chk = 0;
  int   n_fail = 0;
  int   exp_d [C];
  big_t p10 [C+1];

  always #(CLK_PERIOD/2) clk = ~clk;

  dsd_pp_reducer #(.N(N)) u_dut (
    .pp_lo_dig(lo_dig), .pp_lo_inc(lo_inc),
    .pp_top_dig(top_dig), .pp_top_inc(top_inc),
    .prod_dig(prod)
  );

  function automatic big_t ref_sum();
    big_t s = 0;
    for (int k = 0; k < N; k++)
      for (int j = 0; j < W; j++)
        s = s + big_t'(int'($signed(lo_dig[(k*W+j)*4 +: 4])) + int'(lo_inc[k])) * p10[k+j];
    for (int j = 0; j < W; j++)
      s = s + big_t'(int'($signed(top_dig[j*4 +: 4])) + int'(top_inc)) * p10[N+j];
    return s;
  endfunction

  function automatic big_t out_sum();
    big_t s = 0;
    for (int i = 0; i < C; i++) s = s + big_t'(int'($signed(prod[i*4 +: 4]))) * p10[i];
    return s;
  endfunction

  task automatic clear_in();
    lo_dig = '0; lo_inc = '0; top_dig = '0; top_inc = 1'b0;
    for (int i = 0; i < C; i++) exp_d[i] = 0;
  endtask

  task automatic set_top(input int j, input int h);
    top_dig[j*4 +: 4] = 4'(h - int'(top_inc));
  endtask

  task automatic check_mod(input string tag);
    big_t e, a;
    @(negedge clk);
    e = ref_sum(); a = out_sum();
    n_chk++;
    if ((a - e) % p10[C] != 0) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (mod 10^%0d)", tag, a, e, C);
    end
  endtask

  task automatic check_exact(input string tag);
    int bad;
    bad = -1;
    @(negedge clk);
    n_chk++;
    for (int i = C - 1; i >= 0; i--)
      if (int'($signed(prod[i*4 +: 4])) != exp_d[i]) bad = i;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s: digit %0d actual=%0d expected=%0d", tag, bad,
               int'($signed(prod[bad*4 +: 4])), exp_d[bad]);
    end
  endtask

  task automatic rand_in(input bit lo_on, input bit top_on);
    clear_in();
    if (lo_on) begin
      for (int i = 0; i < N*W; i++) lo_dig[i*4 +: 4] = 4'($urandom_range(15, 0));
      lo_inc = N'($urandom);
    end
    if (top_on) begin
      top_inc = 1'($urandom_range(1, 0));
      for (int j = 0; j < N; j++) set_top(j, int'($urandom_range(10, 0)) - 4);
      set_top(N, int'($urandom_range(1, 0)));
      set_top(N + 1, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL R1: watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    p10[0] = 1;
    for (int i = 1; i <= C; i++) p10[i] = p10[i-1] * 10;
    clear_in();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    check_exact("R10 zero inputs");

    for (int k = 0; k < N; k += 5) begin
      @(posedge clk); #1; clear_in();
      lo_dig[(k*W)*4 +: 4] = 4'd1; exp_d[k] = 1;
      check_exact("R3 shift by multiplier position");
    end

    @(posedge clk); #1; clear_in();
    lo_inc[0] = 1'b1;
    for (int p = 0; p <= N + 1; p++) exp_d[p] = 1;
    check_exact("R4 shared increment");

    @(posedge clk); #1; clear_in();
    set_top(0, 6); exp_d[N] = -4; exp_d[N+1] = 1;
    check_exact("R7 slice h=6");

    @(posedge clk); #1; clear_in();
    top_inc = 1'b1;
    for (int j = 0; j < W; j++) set_top(j, 0);
    set_top(0, -4); exp_d[N] = -4;
    check_exact("R7 slice h=-4");

    @(posedge clk); #1; clear_in();
    lo_inc[N-1] = 1'b1;
    for (int j = 0; j < W; j++) lo_dig[((N-1)*W+j)*4 +: 4] = 4'hF;
    lo_dig[((N-1)*W+N+1)*4 +: 4] = 4'd7; exp_d[2*N] = -2;
    check_exact("R9 top transfer dropped");

    @(posedge clk); #1; clear_in();
    for (int i = 0; i < N*W; i++) lo_dig[i*4 +: 4] = 4'd7;
    lo_inc = '1; top_inc = 1'b1;
    for (int j = 0; j < N; j++) set_top(j, 6);
    set_top(N, 1); set_top(N + 1, 0);
    check_mod("R6 R8 all maximum");

    @(posedge clk); #1; clear_in();
    for (int i = 0; i < N*W; i++) lo_dig[i*4 +: 4] = 4'h8;
    for (int j = 0; j < N; j++) set_top(j, -4);
    check_mod("R6 R8 all minimum");

    for (int r = 0; r < 40; r++) begin
      @(posedge clk); #1; rand_in(1'b0, 1'b1);
      check_mod("R5 top operand alone");
    end
    for (int r = 0; r < 40; r++) begin
      @(posedge clk); #1; rand_in(1'b1, 1'b0);
      check_mod("R2 low operands alone");
    end
    for (int r = 0; r < 300; r++) begin
      @(posedge clk); #1; rand_in(1'b1, 1'b1);
      check_mod("R1 random full array");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule